// File: doc/BRIEF.md
# Dual-Clock FIFO with Input-Ready Flag

This block is a single-direction first-in, first-out buffer whose write side and read side run on unrelated clocks. By default it stores 256 words of 36 bits. A producer presents a word with `wr_en`, and the word is taken on the rising `wr_clk` edge if `wr_ready` is high. A consumer sees the oldest word in an output register whenever `rd_valid` is high. It takes that word by raising `rd_en` for one `rd_clk` edge, and the next word, if there is one, moves into the register on that same edge.

Each side keeps a binary pointer one bit wider than the address, so a full array and an empty array can be told apart. Each pointer also has a registered Gray copy, and that copy passes into the other clock domain through two flip-flops. Because of this, space freed by the reader becomes visible to the writer only after a fixed two-edge latency, and new data becomes visible to the reader in the same way.

A word that has moved into the output register no longer occupies the array. With the reader idle, the block therefore accepts one word more than the array depth. A single active-high reset, sampled on each clock, empties the buffer.

Top module: `dcf_fifo`

## Requirements
- R1: While `rst` is high, `wr_ready` and `rd_valid` are both 0. Once reset is released, `wr_ready` is 1 by the second `wr_clk` rising edge and `rd_valid` stays 0.
- R2: Words leave through `rd_data` in the order they were accepted, each word exactly once.
- R3: With `rd_en` held low, exactly DEPTH+1 words are accepted (DEPTH in the array, one in the output register), and `wr_ready` is then 0.
- R4: A word presented while `wr_ready` is 0 changes neither the array nor the write pointer, and it never appears at `rd_data`.
- R5: When the buffer is full, a read that frees the next write location leaves `wr_ready` at 0 after the first `wr_clk` rising edge following that `rd_clk` edge. The second such edge sets `wr_ready` to 1.
- R6: After a write into an empty buffer, `rd_valid` rises on the third `rd_clk` rising edge following the write edge. While `rd_en` is low, `rd_valid` stays 1 and `rd_data` stays unchanged.
- R7: Raising `rd_en` while `rd_valid` is 0 has no effect. The next word written is still delivered correctly.
- R8: Each pointer crosses domains as a registered Gray code that changes at most one bit per clock edge of its own domain.
- R9: Asserting `rst` while data is stored discards every stored word. Afterwards the buffer behaves as empty.
- R10: `wr_ready` falls right after the edge that accepts the word filling the last free location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, sampled on each clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | High when a location is free to take a word |
| rd_en | input | 1 | Consume the word in the output register |
| rd_data | output | DATA_W | Output register contents |
| rd_valid | output | 1 | High when the output register holds a word |

## Verification
The hardest situation to reach from the ports is the reopening of a full buffer. It requires a completely full array plus a loaded output register, then exactly one read, then sampling of `wr_ready` on both sides of each `wr_clk` edge that follows. The bench gets there by writing with the reader idle until no further words are accepted. It then issues a single read. The clock periods are chosen so that no read edge ever falls on a write edge, which makes the two-edge count exact. Words offered while the buffer is closed carry distinct values, so that a leak through the closed write port shows up during the final drain.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 36;

    typedef enum logic {
        WS_HELD = 1'b0,
        WS_RUN  = 1'b1
    } wr_phase_e;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/dcf_g2b.sv
module dcf_g2b #(
    parameter int W = 9
) (
    input  logic [W-1:0] g,
    output logic [W-1:0] b
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b[i] = ^g[W-1:i];
    end

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = DEF_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          wr_accept,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_gray,
    output logic          wr_ready
);

    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

    wr_phase_e   phase;
    logic [AW:0] wbin;
    logic [AW:0] wbin_nx;
    logic [AW:0] rbin_s;
    logic [AW:0] occ;
    logic        full;

    dcf_g2b #(.W(AW+1)) u_g2b (
        .g (rgray_sync),
        .b (rbin_s)
    );

    always_comb begin
        full      = (wbin[AW] != rbin_s[AW]) && (wbin[AW-1:0] == rbin_s[AW-1:0]);
        wr_ready  = (phase == WS_RUN) && !full;
        wr_accept = wr_en && wr_ready;
        wbin_nx   = wbin + {{AW{1'b0}}, wr_accept};
        occ       = wbin - rbin_s;
    end

    assign wr_addr = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= WS_HELD;
            wbin    <= '0;
            wr_gray <= '0;
        end else begin
            phase   <= WS_RUN;
            wbin    <= wbin_nx;
            wr_gray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    AST_WR_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R8
    AST_WR_DROP_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ready) |=> ($stable(wbin) && $stable(wr_gray))); // R4
    AST_WR_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_P); // R3
    AST_WR_READY_LOW_IN_RESET: assert property (@(posedge clk)
        rst |=> !wr_ready); // R1

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = DEF_ADDR_W,
    parameter int DW = DEF_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_gray,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

    logic [AW:0] rbin;
    logic [AW:0] rbin_nx;
    logic [AW:0] wbin_s;
    logic [AW:0] occ;
    logic        array_empty;
    logic        take;
    logic        load;

    dcf_g2b #(.W(AW+1)) u_g2b (
        .g (wgray_sync),
        .b (wbin_s)
    );

    always_comb begin
        array_empty = (rbin == wbin_s);
        take        = rd_valid && rd_en;
        load        = !array_empty && (!rd_valid || take);
        rbin_nx     = rbin + {{AW{1'b0}}, load};
        occ         = wbin_s - rbin;
    end

    assign rd_addr = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin     <= '0;
            rd_gray  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rbin     <= rbin_nx;
            rd_gray  <= rbin_nx ^ (rbin_nx >> 1);
            rd_valid <= load || (rd_valid && !take);
            if (load) begin
                rd_data <= mem_q;
            end
        end
    end

    AST_RD_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R8
    AST_RD_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data))); // R6
    AST_RD_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_valid && array_empty) |=> (!rd_valid && $stable(rbin))); // R7
    AST_RD_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_P); // R2
    AST_RD_VALID_LOW_IN_RESET: assert property (@(posedge clk)
        rst |=> !rd_valid); // R1

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_q;
    logic              wr_accept;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     rgray_in_wr;
    logic [PW-1:0]     wgray_in_rd;

    dcf_wr_side #(.AW(ADDR_W)) u_wr (
        .clk        (wr_clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rgray_sync (rgray_in_wr),
        .wr_accept  (wr_accept),
        .wr_addr    (wr_addr),
        .wr_gray    (wr_gray),
        .wr_ready   (wr_ready)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk (wr_clk),
        .rst (rst),
        .d   (rd_gray),
        .q   (rgray_in_wr)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk (rd_clk),
        .rst (rst),
        .d   (wr_gray),
        .q   (wgray_in_rd)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_accept) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign mem_q = mem[rd_addr];

    dcf_rd_side #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
        .clk        (rd_clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .wgray_sync (wgray_in_rd),
        .mem_q      (mem_q),
        .rd_addr    (rd_addr),
        .rd_gray    (rd_gray),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;

    localparam int AW    = 4;
    localparam int DW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst    = 1'b1;
    logic          wr_en  = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          rd_en  = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_q[$];

    dcf_fifo #(.ADDR_W(AW), .DATA_W(DW)) i_dcf_fifo (
        .wr_clk   (wr_clk),
        .rd_clk   (rd_clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // write edges at 5+10m ns, read edges at 8+14k ns: they never coincide
    initial forever #5 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever #7 rd_clk = ~rd_clk;
    end

    function automatic logic [DW-1:0] pat(input int n);
        return DW'((n * 149 + 37) % 4096);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // call at a wr_clk negedge; returns at the next negedge
    task automatic write_cycle(input logic [DW-1:0] d, output bit acc);
        wr_en   = 1'b1;
        wr_data = d;
        acc     = wr_ready;
        if (acc) exp_q.push_back(d);
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // call at a rd_clk negedge; returns at the next negedge
    task automatic read_cycle(input string tag, output bit got);
        logic [DW-1:0] e;
        got = rd_valid;
        if (got) begin
            if (exp_q.size() == 0) begin
                check(1'b0, tag, int'(rd_data), -1);
            end else begin
                e = exp_q.pop_front();
                check(rd_data == e, tag, int'(rd_data), int'(e));
            end
            rd_en = 1'b1;
        end
        @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_valid(input int maxc);
        int n;
        n = 0;
        while (!rd_valid && n < maxc) begin
            @(negedge rd_clk);
            n++;
        end
    endtask

    task automatic do_reset;
        wr_en = 1'b0;
        rd_en = 1'b0;
        @(negedge wr_clk);
        rst = 1'b1;
        repeat (2) @(posedge wr_clk);
        @(negedge wr_clk);
        check(wr_ready == 1'b0, "R1 ready low in reset", int'(wr_ready), 0);
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R1 valid low in reset", int'(rd_valid), 0);
        @(negedge wr_clk);
        rst = 1'b0;
        exp_q.delete();
        repeat (2) @(posedge wr_clk);
        @(negedge wr_clk);
        check(wr_ready == 1'b1, "R1 ready after release", int'(wr_ready), 1);
        repeat (4) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R1 valid after release", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit acc;
        bit got;
        int cnt;
        logic [DW-1:0] held;

        do_reset();

        // R6: latency of three read edges into an empty buffer, then hold
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = pat(1);
        exp_q.push_back(pat(1));
        @(posedge wr_clk);
        wr_en <= 1'b0;
        @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6 first read edge", int'(rd_valid), 0);
        @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6 second read edge", int'(rd_valid), 0);
        @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_valid == 1'b1, "R6 third read edge", int'(rd_valid), 1);
        held = rd_data;
        repeat (3) @(negedge rd_clk);
        check(rd_valid == 1'b1 && rd_data == held, "R6 hold while idle", int'(rd_data), int'(held));
        read_cycle("R2 single word", got);
        check(rd_valid == 1'b0, "R6 drop after take", int'(rd_valid), 0);

        // R7: rd_en on an empty buffer does nothing
        for (int i = 0; i < 5; i++) begin
            rd_en = 1'b1;
            @(posedge rd_clk);
            @(negedge rd_clk);
            check(rd_valid == 1'b0, "R7 idle read", int'(rd_valid), 0);
        end
        rd_en = 1'b0;
        @(negedge wr_clk);
        write_cycle(pat(2), acc);
        @(negedge rd_clk);
        wait_valid(20);
        read_cycle("R7 word after idle reads", got);
        check(got, "R7 word delivered", int'(got), 1);

        // R3: fill with the reader idle
        @(negedge wr_clk);
        cnt = 0;
        for (int i = 0; i < 3 * DEPTH; i++) begin
            write_cycle(pat(100 + i), acc);
            if (acc) cnt++;
        end
        check(cnt == DEPTH + 1, "R3 accepted words", cnt, DEPTH + 1);
        check(wr_ready == 1'b0, "R3 ready low when full", int'(wr_ready), 0);

        // R5: one read frees a location; two write edges to reopen
        @(negedge rd_clk);
        check(rd_valid == 1'b1 && rd_data == exp_q[0], "R2 head word", int'(rd_data), int'(exp_q[0]));
        void'(exp_q.pop_front());
        rd_en = 1'b1;
        @(posedge rd_clk);
        rd_en <= 1'b0;
        @(posedge wr_clk);
        @(negedge wr_clk);
        check(wr_ready == 1'b0, "R5 first write edge", int'(wr_ready), 0);
        @(posedge wr_clk);
        @(negedge wr_clk);
        check(wr_ready == 1'b1, "R5 second write edge", int'(wr_ready), 1);

        // R10 and R4: one write closes it; further writes are dropped
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            write_cycle(pat(200 + i), acc);
            if (acc) cnt++;
            if (i == 0) check(wr_ready == 1'b0, "R10 ready after last slot", int'(wr_ready), 0);
        end
        check(cnt == 1, "R4 writes while closed", cnt, 1);

        // drain: no dropped word may appear
        cnt = 0;
        @(negedge rd_clk);
        for (int i = 0; i < 120; i++) begin
            read_cycle("R4 drain order", got);
            if (got) cnt++;
        end
        check(cnt == DEPTH + 1, "R4 drained words", cnt, DEPTH + 1);
        check(rd_valid == 1'b0, "R4 empty after drain", int'(rd_valid), 0);

        // R2 R8: concurrent sweeps with differing rates across pointer wraps
        for (int p = 0; p < 4; p++) begin
            fork
                begin
                    bit a;
                    int n;
                    n = 0;
                    @(negedge wr_clk);
                    while (n < 40) begin
                        if ((n + p) % (p + 1) == 0 || p == 0) begin
                            write_cycle(pat(1000 * p + n), a);
                            if (a) n++;
                        end else begin
                            @(negedge wr_clk);
                            n += (p == 3 && n % 2 == 1) ? 0 : 0;
                            write_cycle(pat(1000 * p + n), a);
                            if (a) n++;
                        end
                    end
                end
                begin
                    bit g;
                    int k;
                    int r;
                    k = 0;
                    r = 0;
                    @(negedge rd_clk);
                    while (r < 40 && k < 2000) begin
                        if (k % (4 - p) == 0) begin
                            read_cycle("R2 R8 sweep order", g);
                            if (g) r++;
                        end else begin
                            @(negedge rd_clk);
                        end
                        k++;
                    end
                    check(r == 40, "R2 sweep count", r, 40);
                end
            join
        end

        // R9: reset with data stored
        @(negedge wr_clk);
        for (int i = 0; i < 5; i++) write_cycle(pat(500 + i), acc);
        repeat (10) @(negedge wr_clk);
        do_reset();
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R9 contents discarded", int'(rd_valid), 0);
        check(wr_ready == 1'b1, "R9 ready after reset", int'(wr_ready), 1);
        @(negedge wr_clk);
        write_cycle(pat(777), acc);
        @(negedge rd_clk);
        wait_valid(20);
        read_cycle("R9 first word after reset", got);
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R9 no stale words", int'(rd_valid), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule